// File: doc/BRIEF.md
# Staged Binary-Weighted Bit Rotator

This block rotates an N-bit data word cyclically by an amount from 0 to N-1. The word is first captured into a launch register. It then passes through M = log2(N) cascaded stages of 2:1 multiplexers. Stage i is steered by bit i of the rotate amount: when that bit is 1 the stage moves the word by 2^i positions, and when it is 0 the stage passes the word straight through. Chaining the stages gives any rotation with M levels of muxing and no wide barrel decode.

Each mux cell sits at a (stage, column) location. Its output is qualified by two enables: a row enable shared by every cell of its stage, and a column enable shared by every cell in its bit position. A cell whose row or column enable is low drives 0. Later stages carry that 0 onward, so gating in an early stage shapes the final word. The gated word of the last stage is the result. A parameter can add an output register after the last stage.

Top module: `rot_staged`

## Requirements
- R1: While rst_n is low at a rising clock edge, the launch register clears to all zeros. With every enable high, s then reads 0. When the output register is present, it also clears to 0.
- R2: When load is high at a rising edge, the launch register takes d. With no output register, s reflects the new word in the same cycle after that edge.
- R3: When load is low, the launch register keeps its value. Changes on d then have no effect on s.
- R4: With every enable high, s[j] = q[(j + A) mod N] for each bit j. Here q is the launch register and A is r read as an unsigned number with r[0] as its least significant bit. Stage i contributes a move of 2^i when r[i] = 1.
- R5: For N = 8, load d = 8'hAE (bit 0 first: 0,1,1,1,0,1,0,1) with r = 3'b101 and all enables high. The output is then s = 8'h75 (bit 0 first: 1,0,1,0,1,1,1,0).
- R6: If the row enable eh[i] of any stage i is 0, every cell of that stage outputs 0, and s is all zeros.
- R7: If the column enable ev[j] is 0, the cell in column j of every stage outputs 0. In particular, s[j] is 0.
- R8: Gating applies stage by stage, not only at the end. Let k(-1) = q. Then k(i)[j] = eh[i] & ev[j] & (r[i] ? k(i-1)[(j + 2^i) mod N] : k(i-1)[j]), and s = k(M-1).
- R9: With OUT_REG = 1, s is the R8 result registered on the next rising edge. This adds exactly one cycle of latency.
- R10: With every enable high, the number of ones in s equals the number of ones in the launch register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| load | input | 1 | Captures d into the launch register |
| d | input | N | Data word to rotate |
| r | input | M | Rotate amount, bit i steers stage i |
| eh | input | M | Row enable, one per stage |
| ev | input | N | Column enable, one per bit position |
| s | output | N | Rotated and gated word |

## Verification
The bound checker enforces several rules on every cycle:
- the launch register captures d on load and holds without load;
- a low row enable zeroes the whole output;
- a low column enable zeroes its output bit;
- a zero amount with all enables high returns the launch word;
- with all enables high, the count of ones is preserved.

Some behaviour can only be shown by the bench's scenarios: the exact bit placement of every rotation amount, the worked eight-bit example, and zeros injected in an early stage and then moved by later stages. The bench compares these against a stage-by-stage reference model over table vectors and random data, amounts and enable patterns, for both output variants.

// File: rtl/rot_pkg.sv
// Package: shared helpers for the staged rotator.
// Assumes the word width is a power of two.
package rot_pkg;
    // Column that feeds column col when stage stg moves the word.
    function automatic int src_col(input int col, input int stg, input int width);
        return (col + (1 << stg)) % width;
    endfunction
endpackage

// File: rtl/rot_launch_reg.sv
// Launch register: holds the word that feeds the first rotate stage.
// Assumes a synchronous active-low reset; it loads only when load is high.
module rot_launch_reg #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    // Capture d on load, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/rot_cell.sv
// Rotate cell: a 2:1 mux whose result is ANDed with a row and a column enable.
// Purely combinational.
module rot_cell (
    input  logic pass_in,
    input  logic move_in,
    input  logic sel,
    input  logic row_en,
    input  logic col_en,
    output logic y
);
    // Choose a source, then gate it.
    always_comb y = (sel ? move_in : pass_in) & row_en & col_en;
endmodule

// File: rtl/rot_stage.sv
// Rotate stage STG: moves the word by 2^STG toward bit 0 when sel is high.
// Every column is gated by the shared row enable and its own column enable.
module rot_stage #(
    parameter int N   = 8,
    parameter int STG = 0
) (
    input  logic [N-1:0] din,
    input  logic         sel,
    input  logic         row_en,
    input  logic [N-1:0] col_en,
    output logic [N-1:0] dout
);
    import rot_pkg::*;

    for (genvar j = 0; j < N; j++) begin : g_col
        localparam int SRC = src_col(j, STG, N);
        rot_cell u_cell (
            .pass_in (din[j]),
            .move_in (din[SRC]),
            .sel     (sel),
            .row_en  (row_en),
            .col_en  (col_en[j]),
            .y       (dout[j])
        );
    end
endmodule

// File: rtl/rot_staged.sv
// Staged rotator top: launch register, M mux stages, optional output register.
// Assumes N is a power of two and at least 2. With OUT_REG = 0 the path from the
// launch register to s is combinational; with OUT_REG = 1 it adds one cycle.
module rot_staged #(
    parameter int N       = 8,
    parameter bit OUT_REG = 1'b0,
    localparam int M      = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [N-1:0] d,
    input  logic [M-1:0] r,
    input  logic [M-1:0] eh,
    input  logic [N-1:0] ev,
    output logic [N-1:0] s
);
    logic [N-1:0] launch_q;
    logic [N-1:0] chain [0:M];

    rot_launch_reg #(.N(N)) u_launch (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .d     (d),
        .q     (launch_q)
    );

    // Feed the first stage from the launch register.
    always_comb chain[0] = launch_q;

    for (genvar i = 0; i < M; i++) begin : g_stage
        rot_stage #(.N(N), .STG(i)) u_stage (
            .din    (chain[i]),
            .sel    (r[i]),
            .row_en (eh[i]),
            .col_en (ev),
            .dout   (chain[i+1])
        );
    end

    if (OUT_REG) begin : g_oreg
        logic [N-1:0] s_q;
        // Register the last stage result.
        always_ff @(posedge clk) begin
            if (!rst_n) s_q <= '0;
            else        s_q <= chain[M];
        end
        assign s = s_q;
    end else begin : g_comb
        assign s = chain[M];
    end
endmodule

// File: rtl/rot_staged_chk.sv
// Checker for rot_staged: per-cycle properties on the launch register and
// the gated output. Attached to every instance via bind.
module rot_staged_chk #(
    parameter int N       = 8,
    parameter bit OUT_REG = 1'b0,
    localparam int M      = $clog2(N)
) (
    input logic         clk,
    input logic         rst_n,
    input logic         load,
    input logic [N-1:0] d,
    input logic [M-1:0] r,
    input logic [M-1:0] eh,
    input logic [N-1:0] ev,
    input logic [N-1:0] s,
    input logic [N-1:0] q
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> q == '0);

    assert_load_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> q == $past(d));

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));

    if (OUT_REG) begin : g_reg
        assert_row_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !(&eh) |=> s == '0);
        assert_col_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (s & ~$past(ev)) == '0);
        assert_identity_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (r == '0 && &eh && &ev) |=> s == $past(q));
        assert_popcount_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (&eh && &ev) |=> $countones(s) == $countones($past(q)));
    end else begin : g_comb
        assert_row_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !(&eh) |-> s == '0);
        assert_col_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (s & ~ev) == '0);
        assert_identity_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (r == '0 && &eh && &ev) |-> s == q);
        assert_popcount_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (&eh && &ev) |-> $countones(s) == $countones(q));
    end
endmodule

bind rot_staged rot_staged_chk #(.N(N), .OUT_REG(OUT_REG)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .d     (d),
    .r     (r),
    .eh    (eh),
    .ev    (ev),
    .s     (s),
    .q     (launch_q)
);

// File: tb/rot_staged_test.sv
// Bench: table vectors, random patterns against a stage-by-stage model,
// then directed reset and hold tests. Drives both output variants.
module rot_staged_test;
    localparam int NB = 8;
    localparam int MB = 3;

    typedef struct packed {
        logic [NB-1:0] d;
        logic [MB-1:0] r;
        logic [MB-1:0] eh;
        logic [NB-1:0] ev;
        logic [NB-1:0] exp;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t TBL [NV] = '{
        '{8'hAE, 3'd5, 3'b111, 8'hFF, 8'h75},  // R5 worked example
        '{8'hAE, 3'd0, 3'b111, 8'hFF, 8'hAE},  // R4 amount 0
        '{8'h01, 3'd1, 3'b111, 8'hFF, 8'h80},  // R4 wrap by 1
        '{8'h01, 3'd3, 3'b111, 8'hFF, 8'h20},  // R4 two stages
        '{8'h81, 3'd4, 3'b111, 8'hFF, 8'h18},  // R4 last stage only
        '{8'hF0, 3'd6, 3'b111, 8'hFF, 8'hC3},  // R4 amount 6
        '{8'hFF, 3'd2, 3'b101, 8'hFF, 8'h00},  // R6 middle row off
        '{8'hFF, 3'd0, 3'b111, 8'h0F, 8'h0F},  // R7 column mask
        '{8'h01, 3'd3, 3'b111, 8'h7F, 8'h00}   // R8 early-stage zero
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load = 1'b0;
    logic [NB-1:0] d = '0;
    logic [MB-1:0] r = '0;
    logic [MB-1:0] eh = '1;
    logic [NB-1:0] ev = '1;
    logic [NB-1:0] s, s_reg;
    int            n_chk = 0;
    int            n_bad = 0;
    bit            done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    rot_staged #(.N(NB), .OUT_REG(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .load(load), .d(d),
        .r(r), .eh(eh), .ev(ev), .s(s)
    );

    rot_staged #(.N(NB), .OUT_REG(1'b1)) uut_reg (
        .clk(clk), .rst_n(rst_n), .load(load), .d(d),
        .r(r), .eh(eh), .ev(ev), .s(s_reg)
    );

    // Reference: stage-by-stage gated rotation (R8).
    function automatic logic [NB-1:0] model(input logic [NB-1:0] w, input logic [MB-1:0] a,
                                            input logic [MB-1:0] row, input logic [NB-1:0] col);
        logic [NB-1:0] k = w;
        for (int i = 0; i < MB; i++) begin
            logic [NB-1:0] nk;
            for (int j = 0; j < NB; j++)
                nk[j] = (a[i] ? k[(j + (1 << i)) % NB] : k[j]) & row[i] & col[j];
            k = nk;
        end
        return k;
    endfunction

    task automatic check(input string tag, input logic [NB-1:0] act, input logic [NB-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Load a word, set controls, check both variants.
    task automatic apply(input string tag, input logic [NB-1:0] dv, input logic [MB-1:0] rv,
                         input logic [MB-1:0] ehv, input logic [NB-1:0] evv,
                         input logic [NB-1:0] exp);
        @(negedge clk);
        d = dv; load = 1'b1; r = rv; eh = ehv; ev = evv;
        @(negedge clk);
        load = 1'b0;
        #1 check(tag, s, exp);
        @(negedge clk);
        #1 check({tag, "/R9"}, s_reg, exp);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [NB-1:0] rd, held;
        repeat (3) @(negedge clk);
        #1 check("R1 reset comb", s, 8'h00);
        check("R1 reset reg", s_reg, 8'h00);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++)
            apply(v == 0 ? "R5" : (v < 6 ? "R4" : (v == 6 ? "R6" : (v == 7 ? "R7" : "R8"))),
                  TBL[v].d, TBL[v].r, TBL[v].eh, TBL[v].ev, TBL[v].exp);

        // Random patterns, enables mostly all high.
        for (int t = 0; t < 150; t++) begin
            logic [MB-1:0] rr, ee;
            logic [NB-1:0] cc;
            rd = NB'($urandom);
            rr = MB'($urandom);
            ee = ($urandom % 4 == 0) ? MB'($urandom) : '1;
            cc = ($urandom % 3 == 0) ? NB'($urandom) : '1;
            apply("R8 random", rd, rr, ee, cc, model(rd, rr, ee, cc));
        end

        // R2 / R3: load a word, then change d without load.
        apply("R2 load", 8'h3C, 3'd2, 3'b111, 8'hFF, model(8'h3C, 3'd2, 3'b111, 8'hFF));
        held = s;
        @(negedge clk);
        d = 8'hC5;
        repeat (2) @(negedge clk);
        #1 check("R3 hold", s, held);

        // R1: reset mid-run clears the launch word.
        @(negedge clk);
        rst_n = 1'b0; r = 3'd5;
        repeat (2) @(negedge clk);
        #1 check("R1 mid reset comb", s, 8'h00);
        check("R1 mid reset reg", s_reg, 8'h00);
        rst_n = 1'b1;
        apply("R4 after reset", 8'h12, 3'd7, 3'b111, 8'hFF, model(8'h12, 3'd7, 3'b111, 8'hFF));

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule